// File: doc/BRIEF.md
# Stripe Frame Fill Sequencer

This block walks a 160 by 120 pixel frame from the top-left corner to the bottom-right, one pixel per clock, and presents each pixel on a write port made of a column, a row, a color and a plot strobe. The color is the low three bits of the column, so a frame buffer behind it fills with vertical stripes that repeat every eight columns.

A single-cycle start pulse launches a sweep. Every clock of the sweep writes exactly one pixel. One clock after the final pixel a done pulse is raised and the block goes back to idle, ready for the next start. Registered row and column counters form the datapath. A separate controller state machine steers them through a small bundle of strobes.

Top module: `stripe_fill`

## Requirements
- R1: After a synchronous active-high reset, plot and done are 0 and x and y are both 0.
- R2: A start pulse sampled while idle makes the next cycle the first write, with plot = 1, x = 0 and y = 0.
- R3: Pixels are written in row-major order at one pixel per plot cycle. x counts up by 1 within a row. After x = 159 it goes back to 0 and y goes up by 1.
- R4: During every write, color equals x mod 8, which is bits [2:0] of x.
- R5: x is 8 bits and y is 7 bits. During writes x stays within 0..159 and y stays within 0..119.
- R6: One sweep holds plot high for exactly 19200 consecutive cycles.
- R7: done is high for exactly one cycle, the cycle right after pixel (159,119) is written, and plot is 0 in that cycle.
- R8: A start pulse arriving during a sweep, or in the done cycle, has no effect. The sweep continues at its current position and no extra sweep follows.
- R9: After done, the block is idle with plot at 0, and a new start begins a fresh sweep from (0,0).
- R10: Reset asserted in the middle of a sweep stops it. plot is 0 in the next cycle and the block waits for a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a sweep |
| x | output | 8 | Column of the pixel being written |
| y | output | 7 | Row of the pixel being written |
| color | output | 3 | Color of the pixel being written |
| plot | output | 1 | High in each cycle that writes a pixel |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
Assertions check four things on every cycle: each counter step (increment within a row, wrap at the row end), counter bounds, that start is ignored while running, and that done follows the final pixel and lasts only one cycle. Some properties need a whole frame or a particular ordering of stimuli, and only the bench scenarios show them. These are the exact count of 19200 plot cycles, the stripe color of every pixel, a start pulse landing in the done cycle, a reset in the middle of a sweep, and a restart from (0,0). The bench checks all of these against a behavioural model on every clock.

// File: rtl/stripe_fill_pkg.sv
package stripe_fill_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
  } sweepCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sweepState_e;
endpackage

// File: rtl/stripe_fill_dp.sv
module stripe_fill_dp
  import stripe_fill_pkg::*;
#(
  parameter int COLS = 160,
  parameter int ROWS = 120,
  parameter int XW   = $clog2(COLS),
  parameter int YW   = $clog2(ROWS),
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  sweepCtl_t     ctl,
  output logic [XW-1:0] xPos,
  output logic [YW-1:0] yPos,
  output logic [CW-1:0] color,
  output logic          frameEnd
);
  localparam logic [XW-1:0] LAST_X = XW'(COLS - 1);
  localparam logic [YW-1:0] LAST_Y = YW'(ROWS - 1);

  logic rowEnd;

  assign rowEnd   = (xPos == LAST_X);
  assign frameEnd = rowEnd && (yPos == LAST_Y);
  assign color    = xPos[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      xPos <= '0;
      yPos <= '0;
    end else if (ctl.advance) begin
      if (rowEnd) begin
        xPos <= '0;
        yPos <= yPos + 1'b1;
      end else begin
        xPos <= xPos + 1'b1;
      end
    end
  end

  AST_CLEAR_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> (xPos == '0 && yPos == '0)); // R2
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (ctl.advance && !ctl.clear && xPos != LAST_X) |=>
      (xPos == XW'($past(xPos) + 1'b1) && $stable(yPos))); // R3
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ctl.advance && !ctl.clear && xPos == LAST_X) |=>
      (xPos == '0 && yPos == YW'($past(yPos) + 1'b1))); // R3
  AST_X_BOUND: assert property (@(posedge clk) disable iff (rst)
    xPos <= LAST_X); // R5
  AST_Y_BOUND: assert property (@(posedge clk) disable iff (rst)
    yPos <= LAST_Y); // R5
endmodule

// File: rtl/stripe_fill_ctrl.sv
module stripe_fill_ctrl
  import stripe_fill_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      frameEnd,
  output sweepCtl_t ctl,
  output logic      plot,
  output logic      done
);
  sweepState_e state, nextState;

  always_comb begin
    nextState   = state;
    ctl.clear   = 1'b0;
    ctl.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          nextState = ST_RUN;
          ctl.clear = 1'b1;
        end
      end
      ST_RUN: begin
        if (frameEnd) nextState = ST_DONE;
        else          ctl.advance = 1'b1;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign plot = (state == ST_RUN);
  assign done = (state == ST_DONE);

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && start && !frameEnd) |=> (state == ST_RUN)); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && frameEnd) |=> (done && !plot)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> (state == ST_IDLE)); // R9
  AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> plot); // R2
endmodule

// File: rtl/stripe_fill.sv
module stripe_fill
  import stripe_fill_pkg::*;
#(
  parameter int COLS = 160,
  parameter int ROWS = 120,
  parameter int CW   = 3,
  localparam int XW  = $clog2(COLS),
  localparam int YW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic [CW-1:0] color,
  output logic          plot,
  output logic          done
);
  sweepCtl_t ctlBus;
  logic      frameEnd;

  stripe_fill_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .frameEnd (frameEnd),
    .ctl      (ctlBus),
    .plot     (plot),
    .done     (done)
  );

  stripe_fill_dp #(
    .COLS (COLS),
    .ROWS (ROWS),
    .XW   (XW),
    .YW   (YW),
    .CW   (CW)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctlBus),
    .xPos     (x),
    .yPos     (y),
    .color    (color),
    .frameEnd (frameEnd)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!plot && !done)); // R10
endmodule

// File: tb/stripe_fill_tb.sv
module stripe_fill_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] x;
  logic [6:0] y;
  logic [2:0] color;
  logic       plot, done;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int plotRun = 0;
  bit begun   = 0;
  bit finished = 0;

  // behavioural reference
  bit mRun = 0, mDone = 0;
  int mX = 0, mY = 0;

  always #5 clk = ~clk;

  stripe_fill dut_i (
    .clk(clk), .rst(rst), .start(start),
    .x(x), .y(y), .color(color), .plot(plot), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    begun = 1;
    if (rst) begin
      mRun = 0; mDone = 0; mX = 0; mY = 0;
    end else if (mRun) begin
      if (mX == 159 && mY == 119) begin
        mRun = 0; mDone = 1;
      end else if (mX == 159) begin
        mX = 0; mY = mY + 1;
      end else begin
        mX = mX + 1;
      end
    end else if (mDone) begin
      mDone = 0;
    end else if (start) begin
      mRun = 1; mX = 0; mY = 0;
    end
    if (cycles > 150000 && !finished) begin
      finished = 1;
      check(0, "watchdog R6", cycles, 150000);
      summary();
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (begun) begin
      check(plot == mRun, "R3 plot", plot, mRun);
      check(done == mDone, "R7 done", done, mDone);
      if (mRun && plot) begin
        check(x == mX, "R3 x", x, mX);
        check(y == mY, "R3 y", y, mY);
        check(color == 3'(mX % 8), "R4 color", color, mX % 8);
        check(x <= 159 && y <= 119, "R5 range", x, 159);
      end
      if (plot) plotRun++;
    end
  end

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(plot == 0 && done == 0, "R1 outputs", {plot, done}, 0);
    check(x == 0 && y == 0, "R1 counters", {x, y}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(plot == 0, "R1 idle", plot, 0);

    // first sweep with a stray start in the middle
    plotRun = 0;
    pulseStart();
    check(plot == 1 && x == 0 && y == 0, "R2 first pixel", {plot, x, y}, 16'h8000 >> 0 == 0 ? 0 : 32768);
    repeat (5000) @(negedge clk);
    pulseStart();
    check(plot == 1, "R8 running", plot, 1);
    waitDone();
    check(plotRun == 19200, "R6 plot cycles", plotRun, 19200);
    check(plot == 0, "R7 no plot with done", plot, 0);
    // start during done cycle must be dropped
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done == 0 && plot == 0, "R8 done-cycle start", {plot, done}, 0);
    repeat (3) @(negedge clk);
    check(plot == 0, "R9 idle after done", plot, 0);

    // reset mid-sweep
    pulseStart();
    repeat (700) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(plot == 0 && done == 0, "R10 reset stops", {plot, done}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(plot == 0, "R10 stays idle", plot, 0);

    // fresh full sweep
    plotRun = 0;
    pulseStart();
    check(plot == 1 && x == 0 && y == 0, "R9 restart origin", {x, y}, 0);
    waitDone();
    check(plotRun == 19200, "R6 second sweep", plotRun, 19200);
    @(negedge clk);
    check(done == 0, "R7 single pulse", done, 0);
    finished = 1;
    summary();
  end
endmodule